// File: doc/BRIEF.md
# Synchronized Even-Ratio Clock Channel Divider

This block is the digital core of a multi-channel clock fan-out stage. One shared front end takes an active-low synchronization request. It passes the request through a metastability synchronizer and then a fixed-latency pipeline. Each output channel holds an 8-bit divide code and a 2-bit mode. A channel can pass the distribution clock straight through, or it can produce an even-ratio divided clock with a 50% duty cycle. When a sync request arrives, every divided channel is parked low. When the request is lifted, all divided channels restart high on one common edge, so they leave the event phase-aligned. Bypassed channels never see the sync request.

The final output of each channel is gated by four controls: the channel's own enable, a global enable bit, a global enable pin and a power-down bit. A gated channel drives a defined low level and raises a separate off flag. The delay selection bit of the mode is not modelled as a delay. It is only reported on a per-channel flag.

The shared front end has two states. SF_RUN moves to SF_HOLD when the pipelined request reads low, and SF_HOLD moves back to SF_RUN when it reads high. Each channel divider has three states:
- DV_HOLD goes to DV_HIGH on release.
- DV_HIGH goes to DV_LOW when its half-period count completes.
- DV_LOW goes to DV_HIGH when its half-period count completes.
- DV_HIGH and DV_LOW both go to DV_HOLD whenever the hold is active.

Top module: `clkdist_channels`

## Requirements
- R1: A channel in a divided mode with code N (1..255) produces a clock of period 2N distribution cycles. After release it is high for N cycles, then low for N cycles, and this repeats.
- R2: A divide code of 0 behaves exactly like code 1, giving ratio 2.
- R3: Mode bit 0 selects the output source: 1 (modes 1 and 3) gives the divided clock, and 0 (modes 0 and 2) gives the distribution clock itself. Mode bit 1 is reported unchanged on the channel's `dly_o` bit.
- R4: Suppose `sync_ni` is changed between edges and the next rising edge is counted as edge 1. Then divided outputs are forced low from edge 6 onward: 2 synchronizer stages plus a 4-cycle latency. They stay low while the request remains low.
- R5: After `sync_ni` returns high, counting the same way, every divided output is still low after edge 5. All divided outputs go high together at edge 6, and each starts a fresh half-period count there.
- R6: Channels in modes 0 and 2 follow the distribution clock whether or not a sync request is active.
- R7: A channel output is live only when its enable bit, `glob_en_bit_i` and `glob_en_pin_i` are all 1. Otherwise the output is 0 and its `off_o` bit is 1.
- R8: When `pwr_down_i` is 1, every channel is off (`off_o` = 1, `clk_o` = 0), whatever the other controls are.
- R9: While `rst_ni` is low, every divided channel output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Distribution clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_ni | input | 1 | Active-low synchronization request (asynchronous) |
| mode_i | input | 2*NUM_CH | Per-channel mode, channel g at bits [2g+1:2g] |
| div_code_i | input | CODE_W*NUM_CH | Per-channel divide code, channel g at bits [CODE_W*g +: CODE_W] |
| chan_en_i | input | NUM_CH | Per-channel output enable |
| glob_en_bit_i | input | 1 | Global enable control bit |
| glob_en_pin_i | input | 1 | Global enable pin |
| pwr_down_i | input | 1 | Power-down, overrides all enables |
| clk_o | output | NUM_CH | Gated channel clocks |
| off_o | output | NUM_CH | Per-channel off flag |
| dly_o | output | NUM_CH | Per-channel delay-selection flag (mode bit 1) |

## Verification
The bench builds the block with three channels, 8-bit codes, a two-stage synchronizer and a latency of four. Three channels are enough to run bypassed and divided channels side by side through one sync event, and to show that divided channels of different ratios restart on the same edge. The random codes are kept between 1 and 6 so that several full periods fit into each observation window. Directed runs cover code 0, power-down, the global pin and the reset state.

// File: rtl/clkdist_pkg.sv
package clkdist_pkg;

    typedef enum logic [1:0] {
        MODE_BYPASS  = 2'd0,
        MODE_DIV     = 2'd1,
        MODE_DLY     = 2'd2,
        MODE_DIV_DLY = 2'd3
    } chmode_e;

    typedef enum logic [1:0] {
        DV_HOLD = 2'd0,
        DV_HIGH = 2'd1,
        DV_LOW  = 2'd2
    } divst_e;

    typedef enum logic {
        SF_RUN  = 1'b0,
        SF_HOLD = 1'b1
    } syncst_e;

endpackage

// File: rtl/sync_front.sv
module sync_front #(
    parameter int SYNC_STAGES = 2,
    parameter int LAT         = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sync_ni,
    output logic held_o
);
    import clkdist_pkg::*;

    // The last latency stage is the state register, and the divider
    // register forms the final one, so LAT-2 plain pipeline stages remain.
    localparam int PIPE_D = LAT - 2;

    logic [SYNC_STAGES-1:0] meta_q;
    logic [PIPE_D-1:0]      pipe_q;
    syncst_e                state_q, state_d;

    initial begin
        if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");
        if (LAT < 3)         $error("LAT must be at least 3");
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            meta_q <= '1;
            pipe_q <= '1;
        end else begin
            meta_q[0] <= sync_ni;
            for (int k = 1; k < SYNC_STAGES; k++) meta_q[k] <= meta_q[k-1];
            pipe_q[0] <= meta_q[SYNC_STAGES-1];
            for (int k = 1; k < PIPE_D; k++) pipe_q[k] <= pipe_q[k-1];
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SF_RUN:  if (!pipe_q[PIPE_D-1]) state_d = SF_HOLD;
            SF_HOLD: if (pipe_q[PIPE_D-1])  state_d = SF_RUN;
            default: state_d = SF_RUN;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= SF_RUN;
        else         state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            SF_HOLD: held_o = 1'b1;
            default: held_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/ch_divider.sv
module ch_divider #(
    parameter int CODE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              held_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              div_o
);
    import clkdist_pkg::*;

    divst_e            state_q, state_d;
    logic [CODE_W-1:0] cnt_q, cnt_d;
    logic [CODE_W-1:0] eff;
    logic              last;

    // Code zero is not a legal ratio; it is mapped onto ratio 2.
    assign eff  = (code_i == '0) ? CODE_W'(1) : code_i;
    assign last = (cnt_q >= eff - 1'b1);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            DV_HOLD: begin
                cnt_d = '0;
                if (!held_i) state_d = DV_HIGH;
            end
            DV_HIGH: begin
                if (held_i) begin
                    state_d = DV_HOLD;
                    cnt_d   = '0;
                end else if (last) begin
                    state_d = DV_LOW;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            DV_LOW: begin
                if (held_i) begin
                    state_d = DV_HOLD;
                    cnt_d   = '0;
                end else if (last) begin
                    state_d = DV_HIGH;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = DV_HOLD;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= DV_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        unique case (state_q)
            DV_HIGH: div_o = 1'b1;
            default: div_o = 1'b0;
        endcase
    end

    AST_HOLD_FORCES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        held_i |=> !div_o); // R4

    AST_RELEASE_GOES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == DV_HOLD && !held_i) |=> div_o); // R5

    AST_HALF_PERIOD_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($stable(code_i) && state_q != DV_HOLD) |-> (cnt_q < eff)); // R1

endmodule

// File: rtl/out_gate.sv
module out_gate (
    input  logic       clk_i,
    input  logic [1:0] mode_i,
    input  logic       div_i,
    input  logic       chan_en_i,
    input  logic       glob_en_bit_i,
    input  logic       glob_en_pin_i,
    input  logic       pwr_down_i,
    output logic       clk_o,
    output logic       off_o,
    output logic       dly_o
);
    import clkdist_pkg::*;

    logic live;
    logic src;

    assign live = chan_en_i & glob_en_bit_i & glob_en_pin_i & ~pwr_down_i;

    always_comb begin
        unique case (chmode_e'(mode_i))
            MODE_DIV, MODE_DIV_DLY: src = div_i;
            default:                src = clk_i;
        endcase
    end

    assign clk_o = live & src;
    assign off_o = ~live;
    assign dly_o = mode_i[1];

endmodule

// File: rtl/clkdist_channels.sv
module clkdist_channels #(
    parameter int NUM_CH      = 3,
    parameter int CODE_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int LAT         = 4
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     sync_ni,
    input  logic [2*NUM_CH-1:0]      mode_i,
    input  logic [CODE_W*NUM_CH-1:0] div_code_i,
    input  logic [NUM_CH-1:0]        chan_en_i,
    input  logic                     glob_en_bit_i,
    input  logic                     glob_en_pin_i,
    input  logic                     pwr_down_i,
    output logic [NUM_CH-1:0]        clk_o,
    output logic [NUM_CH-1:0]        off_o,
    output logic [NUM_CH-1:0]        dly_o
);
    logic              held;
    logic [NUM_CH-1:0] div_q;

    sync_front #(
        .SYNC_STAGES(SYNC_STAGES),
        .LAT        (LAT)
    ) u_front (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sync_ni(sync_ni),
        .held_o (held)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ch_divider #(
            .CODE_W(CODE_W)
        ) u_div (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .held_i(held),
            .code_i(div_code_i[CODE_W*g +: CODE_W]),
            .div_o (div_q[g])
        );

        out_gate u_gate (
            .clk_i        (clk_i),
            .mode_i       (mode_i[2*g +: 2]),
            .div_i        (div_q[g]),
            .chan_en_i    (chan_en_i[g]),
            .glob_en_bit_i(glob_en_bit_i),
            .glob_en_pin_i(glob_en_pin_i),
            .pwr_down_i   (pwr_down_i),
            .clk_o        (clk_o[g]),
            .off_o        (off_o[g]),
            .dly_o        (dly_o[g])
        );
    end

    AST_PD_ALL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwr_down_i |-> (&off_o && clk_o == '0)); // R8

    AST_OFF_DRIVES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|off_o) |-> ((off_o & clk_o) == '0)); // R7

    AST_HELD_DIV_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        held |=> (div_q == '0)); // R4

endmodule

// File: tb/sim_clkdist_channels.sv
module sim_clkdist_channels;
    localparam int NUM_CH = 3;
    localparam int CODE_W = 8;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     sync_n = 1'b1;
    logic [2*NUM_CH-1:0]      mode = '0;
    logic [CODE_W*NUM_CH-1:0] code = '0;
    logic [NUM_CH-1:0]        en = '0;
    logic                     gbit = 1'b1;
    logic                     gpin = 1'b1;
    logic                     pd = 1'b0;
    logic [NUM_CH-1:0]        clk_o, off_o, dly_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    clkdist_channels #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .sync_ni(sync_n), .mode_i(mode),
        .div_code_i(code), .chan_en_i(en), .glob_en_bit_i(gbit),
        .glob_en_pin_i(gpin), .pwr_down_i(pd),
        .clk_o(clk_o), .off_o(off_o), .dly_o(dly_o)
    );

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    function automatic logic live(input int ch);
        return en[ch] & gbit & gpin & ~pd;
    endfunction

    function automatic int eff_code(input int ch);
        int c = int'(code[CODE_W*ch +: CODE_W]);
        return (c == 0) ? 1 : c;
    endfunction

    // Expected level sampled just after a rising edge (clock high);
    // j counts edges from the release edge, j = 0 on that edge.
    function automatic logic exp_run(input int ch, input int j);
        if (!live(ch)) return 1'b0;
        if (!mode[2*ch]) return 1'b1;
        return ((j / eff_code(ch)) % 2) == 0;
    endfunction

    task automatic sync_event(input int span, input string divreq);
        @(negedge clk) sync_n = 1'b0;
        repeat (7) @(posedge clk);
        #2;
        for (int c = 0; c < NUM_CH; c++) begin
            if (mode[2*c]) chk(clk_o[c], 1'b0, "R4", $sformatf("ch%0d held low", c));
            else           chk(clk_o[c], live(c), "R6", $sformatf("ch%0d bypass during hold", c));
        end
        @(negedge clk) sync_n = 1'b1;
        repeat (5) @(posedge clk);
        #2;
        for (int c = 0; c < NUM_CH; c++)
            if (mode[2*c]) chk(clk_o[c], 1'b0, "R5", $sformatf("ch%0d still low after edge 5", c));
        for (int j = 0; j < span; j++) begin
            @(posedge clk);
            #2;
            for (int c = 0; c < NUM_CH; c++) begin
                chk(clk_o[c], exp_run(c, j), mode[2*c] ? divreq : "R3 R6",
                    $sformatf("ch%0d level at j=%0d", c, j));
                chk(off_o[c], ~live(c), "R7", $sformatf("ch%0d off flag", c));
                chk(dly_o[c], mode[2*c+1], "R3", $sformatf("ch%0d delay flag", c));
            end
        end
    endtask

    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        mode = {2'd0, 2'd1, 2'd3};
        code = {8'd2, 8'd3, 8'd1};
        en   = '1;
        repeat (3) @(posedge clk);
        #2;
        // R9: divided channels are low while reset is held
        chk(clk_o[0], 1'b0, "R9", "ch0 in reset");
        chk(clk_o[1], 1'b0, "R9", "ch1 in reset");
        @(negedge clk) rst_n = 1'b1;

        // Directed: mixed modes with ratios 2, 6, bypass
        sync_event(16, "R1 R5");

        // Directed R2: code 0 behaves as ratio 2
        @(negedge clk);
        mode = {2'd1, 2'd3, 2'd1};
        code = {8'd0, 8'd4, 8'd0};
        sync_event(12, "R2");

        // Directed R3: delayed-only mode acts as bypass
        @(negedge clk);
        mode = {2'd2, 2'd2, 2'd1};
        code = {8'd5, 8'd5, 8'd2};
        sync_event(8, "R3");

        // Directed R7: global pin low turns everything off
        @(negedge clk) gpin = 1'b0;
        @(posedge clk);
        #2;
        for (int c = 0; c < NUM_CH; c++) begin
            chk(off_o[c], 1'b1, "R7", $sformatf("ch%0d off with pin low", c));
            chk(clk_o[c], 1'b0, "R7", $sformatf("ch%0d low with pin low", c));
        end
        @(negedge clk) begin gpin = 1'b1; gbit = 1'b0; end
        @(posedge clk);
        #2;
        chk(off_o[0], 1'b1, "R7", "ch0 off with global bit clear");

        // Directed R8: power-down overrides all enables
        @(negedge clk) begin gbit = 1'b1; pd = 1'b1; end
        for (int k = 0; k < 4; k++) begin
            @(posedge clk);
            #2;
            for (int c = 0; c < NUM_CH; c++) begin
                chk(off_o[c], 1'b1, "R8", $sformatf("ch%0d off in power-down", c));
                chk(clk_o[c], 1'b0, "R8", $sformatf("ch%0d low in power-down", c));
            end
        end
        @(negedge clk) pd = 1'b0;

        // Random configurations
        for (int it = 0; it < 24; it++) begin
            @(negedge clk);
            for (int c = 0; c < NUM_CH; c++) begin
                mode[2*c +: 2]        = 2'($urandom_range(3, 0));
                code[CODE_W*c +: CODE_W] = CODE_W'($urandom_range(6, 1));
                en[c]                 = ($urandom_range(3, 0) != 0);
            end
            gbit = ($urandom_range(7, 0) != 0);
            gpin = ($urandom_range(7, 0) != 0);
            pd   = ($urandom_range(9, 0) == 0);
            sync_event(28, "R1 R5");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule